// File: doc/BRIEF.md
# Debug Comparator Event Qualifier

This block sits behind a bank of breakpoint or watchpoint address comparators. The address comparison happens elsewhere. Each comparator that sees an address hit raises one bit of `rawHit`, and this block decides whether that hit turns into a debug event. For each comparator it decodes the 64-bit control word and tests it against three things: the current security state, the current privilege level (0 to 3), and an override for unprivileged accesses. When the word asks for it, the block also tests a linked context-ID comparator, which is taken from a separate bank of link entries.

All comparators are qualified in parallel. The result is registered one cycle after the hit strobe. It is reported as a per-comparator vector of qualified hits together with the OR of that vector. Matching is held off entirely when the global debug enable is low or when debug events cannot currently be taken.

Top module: `dbg_event_qualifier`

## Requirements
- R1: `qualHits` and `anyHit` are registered. They show the result for the inputs present at the clock edge where `hitValid` was high, one cycle later. After any edge where `hitValid` was low, both read zero, and both are zero out of reset.
- R2: Comparator i can only qualify if `rawHit[i]` was high at the sampling edge.
- R3: The security field is control bits [15:14]. A value of 0 accepts either state. A value of 1 or 3 accepts only non-secure (`secure`=0). A value of 2 accepts only secure (`secure`=1).
- R4: Level 2 or 3 requires control bit 13 to be set. Level 1 requires control bit 1 to be set. Level 0 requires control bit 2 to be set.
- R5: When `isWatch`=1 and `unprivAccess`=1, the level check of R4 uses level 0, whatever `curLevel` is. When `isWatch`=0, `unprivAccess` has no effect.
- R6: When `debugEnable`=0 or `eventsAllowed`=0 at the sampling edge, no comparator qualifies.
- R7: When control bit 20 is set, the comparator also needs the link entry numbered by control bits [19:16]. A link number above LINK_TOP, or below LINK_TOP-CTX_FIELD, never qualifies.
- R8: A link entry qualifies only when its enable bit 0 is set and its type field, bits [23:20], equals 3.
- R9: A linked match also needs the entry's 32-bit value to equal `contextId`, and needs `curLevel` to be at most 1. The override of R5 does not change this level test.
- R10: `anyHit` equals the OR of `qualHits` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hitValid | input | 1 | Strobe: `rawHit` and the state inputs are valid this cycle |
| rawHit | input | NUM_CMP | Address hit from each comparator |
| isWatch | input | 1 | 1 = the comparators are watchpoints, 0 = breakpoints |
| unprivAccess | input | 1 | The access was an unprivileged-form access |
| secure | input | 1 | Current security state, 1 = secure |
| curLevel | input | 2 | Current privilege level |
| debugEnable | input | 1 | Global debug enable |
| eventsAllowed | input | 1 | Debug events can be taken now |
| ctrlWords | input | NUM_CMP*64 | Control word of each comparator, comparator i at [i*64 +: 64] |
| linkCtrl | input | (LINK_TOP+1)*64 | Control word of each link entry |
| linkVal | input | (LINK_TOP+1)*32 | Context value of each link entry |
| contextId | input | 32 | Current context ID |
| qualHits | output | NUM_CMP | Registered qualified hit per comparator |
| anyHit | output | 1 | Registered OR of the qualified hits |

## Verification
The bench builds the block with its defaults: four comparators and link entries 0 to 5, of which only entries 4 and 5 are context-aware. With these values a 4-bit link number can land in all three regions: below the context-aware range (0 to 3), inside it (4 and 5), and above the bank (6 to 15). The random traffic therefore reaches every link rejection path, alongside directed cases for each security and level combination.

// File: rtl/dbg_qual_pkg.sv
package dbg_qual_pkg;
  localparam int CTRL_W   = 64;
  localparam int VAL_W    = 32;
  localparam int LINK_IDX_W = 4;
  localparam int PRIV_LO  = 1;
  localparam int HIGH_BIT = 13;
  localparam int SEC_LO   = 14;
  localparam int LNUM_LO  = 16;
  localparam int LINKED_BIT = 20;
  localparam int LEN_BIT  = 0;
  localparam int LTYPE_LO = 20;
  localparam logic [3:0] LTYPE_CTX = 4'd3;

  typedef struct packed {
    logic load;
    logic clear;
  } qualStrobe_t;
endpackage

// File: rtl/dbg_qual_ctrl.sv
module dbg_qual_ctrl
  import dbg_qual_pkg::*;
(
  input  logic        hitValid,
  input  logic        debugEnable,
  input  logic        eventsAllowed,
  input  logic        isWatch,
  input  logic        unprivAccess,
  input  logic [1:0]  curLevel,
  output qualStrobe_t strobes,
  output logic [1:0]  accessLevel
);
  always_comb begin
    strobes.load  = hitValid && debugEnable && eventsAllowed;
    strobes.clear = !strobes.load;
    accessLevel   = (isWatch && unprivAccess) ? 2'd0 : curLevel;
  end
endmodule

// File: rtl/dbg_qual_dpath.sv
module dbg_qual_dpath
  import dbg_qual_pkg::*;
#(
  parameter int NUM_CMP   = 4,
  parameter int LINK_TOP  = 5,
  parameter int CTX_FIELD = 1
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  qualStrobe_t                     strobes,
  input  logic [1:0]                      accessLevel,
  input  logic [1:0]                      curLevel,
  input  logic                            secure,
  input  logic [NUM_CMP-1:0]              rawHit,
  input  logic [NUM_CMP*CTRL_W-1:0]       ctrlWords,
  input  logic [(LINK_TOP+1)*CTRL_W-1:0]  linkCtrl,
  input  logic [(LINK_TOP+1)*VAL_W-1:0]   linkVal,
  input  logic [VAL_W-1:0]                contextId,
  output logic [NUM_CMP-1:0]              qualHits,
  output logic                            anyHit
);
  localparam int LINK_SPAN = 1 << LINK_IDX_W;
  localparam int LINK_LO   = LINK_TOP - CTX_FIELD;

  logic [LINK_SPAN-1:0] linkOkVec;
  logic [NUM_CMP-1:0]   qualNext;
  logic                 ctxLevelOk;

  assign ctxLevelOk = (curLevel <= 2'd1);

  for (genvar j = 0; j < LINK_SPAN; j++) begin : g_link
    if (j >= LINK_LO && j <= LINK_TOP) begin : g_impl
      logic [CTRL_W-1:0] lw;
      assign lw = linkCtrl[j*CTRL_W +: CTRL_W];
      assign linkOkVec[j] = lw[LEN_BIT] && (lw[LTYPE_LO +: 4] == LTYPE_CTX) &&
                            ctxLevelOk && (linkVal[j*VAL_W +: VAL_W] == contextId);
    end else begin : g_none
      assign linkOkVec[j] = 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    logic [CTRL_W-1:0] cw;
    logic secOk, lvlOk, linkOk;
    assign cw = ctrlWords[i*CTRL_W +: CTRL_W];

    always_comb begin
      unique case (cw[SEC_LO +: 2])
        2'd0:    secOk = 1'b1;
        2'd2:    secOk = secure;
        default: secOk = !secure;
      endcase
      if (accessLevel >= 2'd2)      lvlOk = cw[HIGH_BIT];
      else if (accessLevel == 2'd1) lvlOk = cw[PRIV_LO];
      else                          lvlOk = cw[PRIV_LO+1];
      linkOk = !cw[LINKED_BIT] || linkOkVec[cw[LNUM_LO +: LINK_IDX_W]];
    end

    assign qualNext[i] = rawHit[i] && secOk && lvlOk && linkOk;

    assert_raw_needed_R2: assert property (@(posedge clk) disable iff (!rstN)
      qualHits[i] |-> $past(rawHit[i]));
    assert_high_level_R4: assert property (@(posedge clk) disable iff (!rstN)
      (qualHits[i] && $past(accessLevel) >= 2'd2) |-> $past(ctrlWords[i*CTRL_W + HIGH_BIT]));
    assert_link_level_R9: assert property (@(posedge clk) disable iff (!rstN)
      (qualHits[i] && $past(ctrlWords[i*CTRL_W + LINKED_BIT])) |-> ($past(curLevel) <= 2'd1));
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clear) begin
      qualHits <= '0;
      anyHit   <= 1'b0;
    end else begin
      qualHits <= qualNext;
      anyHit   <= |qualNext;
    end
  end

  assert_any_or_R10: assert property (@(posedge clk) disable iff (!rstN)
    anyHit == (|qualHits));
endmodule

// File: rtl/dbg_event_qualifier.sv
module dbg_event_qualifier
  import dbg_qual_pkg::*;
#(
  parameter int NUM_CMP   = 4,
  parameter int LINK_TOP  = 5,
  parameter int CTX_FIELD = 1
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            hitValid,
  input  logic [NUM_CMP-1:0]              rawHit,
  input  logic                            isWatch,
  input  logic                            unprivAccess,
  input  logic                            secure,
  input  logic [1:0]                      curLevel,
  input  logic                            debugEnable,
  input  logic                            eventsAllowed,
  input  logic [NUM_CMP*64-1:0]           ctrlWords,
  input  logic [(LINK_TOP+1)*64-1:0]      linkCtrl,
  input  logic [(LINK_TOP+1)*32-1:0]      linkVal,
  input  logic [31:0]                     contextId,
  output logic [NUM_CMP-1:0]              qualHits,
  output logic                            anyHit
);
  qualStrobe_t strobes;
  logic [1:0]  accessLevel;

  dbg_qual_ctrl u_ctrl (
    .hitValid(hitValid), .debugEnable(debugEnable), .eventsAllowed(eventsAllowed),
    .isWatch(isWatch), .unprivAccess(unprivAccess), .curLevel(curLevel),
    .strobes(strobes), .accessLevel(accessLevel)
  );

  dbg_qual_dpath #(.NUM_CMP(NUM_CMP), .LINK_TOP(LINK_TOP), .CTX_FIELD(CTX_FIELD)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .accessLevel(accessLevel),
    .curLevel(curLevel), .secure(secure), .rawHit(rawHit), .ctrlWords(ctrlWords),
    .linkCtrl(linkCtrl), .linkVal(linkVal), .contextId(contextId),
    .qualHits(qualHits), .anyHit(anyHit)
  );

  assert_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    anyHit |-> $past(hitValid && debugEnable && eventsAllowed));
  assert_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(hitValid) |-> (qualHits == '0));
endmodule

// File: tb/dbg_event_qualifier_tb.sv
`timescale 1ns/1ps
module dbg_event_qualifier_tb;
  localparam int NUM_CMP = 4;
  localparam int LINK_TOP = 5;
  localparam int CTX_FIELD = 1;
  localparam int LE = LINK_TOP + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hitValid = 1'b0;
  logic [NUM_CMP-1:0] rawHit = '0;
  logic isWatch = 1'b0, unprivAccess = 1'b0, secure = 1'b0;
  logic [1:0] curLevel = 2'd1;
  logic debugEnable = 1'b1, eventsAllowed = 1'b1;
  logic [NUM_CMP*64-1:0] ctrlWords = '0;
  logic [LE*64-1:0] linkCtrl = '0;
  logic [LE*32-1:0] linkVal = '0;
  logic [31:0] contextId = 32'h1234_5678;
  logic [NUM_CMP-1:0] qualHits;
  logic anyHit;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dbg_event_qualifier #(.NUM_CMP(NUM_CMP), .LINK_TOP(LINK_TOP), .CTX_FIELD(CTX_FIELD)) u_dut (
    .clk(clk), .rstN(rstN), .hitValid(hitValid), .rawHit(rawHit), .isWatch(isWatch),
    .unprivAccess(unprivAccess), .secure(secure), .curLevel(curLevel),
    .debugEnable(debugEnable), .eventsAllowed(eventsAllowed), .ctrlWords(ctrlWords),
    .linkCtrl(linkCtrl), .linkVal(linkVal), .contextId(contextId),
    .qualHits(qualHits), .anyHit(anyHit)
  );

  function automatic logic [63:0] mkCtrl(int pac, int hmc, int ssc, int lbn, int wt);
    logic [63:0] w;
    w = '0;
    w[2:1] = pac[1:0];
    w[13] = hmc[0];
    w[15:14] = ssc[1:0];
    w[19:16] = lbn[3:0];
    w[20] = wt[0];
    return w;
  endfunction

  function automatic logic [63:0] mkLink(int en, int typ);
    logic [63:0] w;
    w = '0;
    w[0] = en[0];
    w[23:20] = typ[3:0];
    return w;
  endfunction

  function automatic bit modelBit(int i);
    logic [63:0] c;
    logic [63:0] l;
    int lvl;
    int n;
    c = ctrlWords[i*64 +: 64];
    lvl = (isWatch && unprivAccess) ? 0 : int'(curLevel);
    if (!rawHit[i]) return 0;
    if ((c[15:14] == 2'd1 || c[15:14] == 2'd3) && secure) return 0;
    if (c[15:14] == 2'd2 && !secure) return 0;
    if (lvl >= 2 && !c[13]) return 0;
    if (lvl == 1 && !c[1]) return 0;
    if (lvl == 0 && !c[2]) return 0;
    if (c[20]) begin
      n = int'(c[19:16]);
      if (n > LINK_TOP || n < LINK_TOP - CTX_FIELD) return 0;
      l = linkCtrl[n*64 +: 64];
      if (!l[0] || l[23:20] != 4'd3) return 0;
      if (curLevel > 2'd1) return 0;
      if (linkVal[n*32 +: 32] != contextId) return 0;
    end
    return 1;
  endfunction

  task automatic cycle(input string tag);
    logic [NUM_CMP-1:0] expV;
    expV = '0;
    if (hitValid && debugEnable && eventsAllowed)
      for (int i = 0; i < NUM_CMP; i++) expV[i] = modelBit(i);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (qualHits !== expV || anyHit !== (|expV)) begin
      errors++;
      $display("FAIL %s: qualHits=%b anyHit=%b expected %b %b", tag, qualHits, anyHit, expV, |expV);
    end
  endtask

  task automatic setAll(input logic [63:0] w);
    for (int i = 0; i < NUM_CMP; i++) ctrlWords[i*64 +: 64] = w;
  endtask

  task automatic finishRun;
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (qualHits !== '0 || anyHit !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: %b %b expected 0 0", qualHits, anyHit);
    end
    rstN = 1'b1;
    // R1: no strobe -> zero
    setAll(mkCtrl(3, 1, 0, 0, 0)); rawHit = 4'b1111; hitValid = 1'b0;
    cycle("R1 no strobe");
    // R2 / R10: only raw-hit indices
    hitValid = 1'b1; rawHit = 4'b0101; cycle("R2 R10 partial raw hits");
    rawHit = 4'b0000; cycle("R2 no raw hits");
    rawHit = 4'b1111;
    // R3 security
    setAll(mkCtrl(3, 1, 2, 0, 0)); secure = 0; cycle("R3 ssc2 nonsecure");
    secure = 1; cycle("R3 ssc2 secure");
    setAll(mkCtrl(3, 1, 1, 0, 0)); cycle("R3 ssc1 secure");
    setAll(mkCtrl(3, 1, 3, 0, 0)); secure = 0; cycle("R3 ssc3 nonsecure");
    setAll(mkCtrl(3, 1, 0, 0, 0)); secure = 1; cycle("R3 ssc0 secure");
    // R4 levels
    secure = 0;
    setAll(mkCtrl(3, 0, 0, 0, 0)); curLevel = 2; cycle("R4 level2 no high bit");
    curLevel = 3; cycle("R4 level3 no high bit");
    setAll(mkCtrl(0, 1, 0, 0, 0)); cycle("R4 level3 high bit");
    curLevel = 0; setAll(mkCtrl(1, 1, 0, 0, 0)); cycle("R4 level0 pac01");
    setAll(mkCtrl(2, 1, 0, 0, 0)); cycle("R4 level0 pac10");
    curLevel = 1; cycle("R4 level1 pac10");
    // R5 unprivileged override
    isWatch = 1; unprivAccess = 1; curLevel = 1; cycle("R5 watch unpriv pac10 at level1");
    setAll(mkCtrl(1, 1, 0, 0, 0)); cycle("R5 watch unpriv pac01 at level1");
    curLevel = 3; setAll(mkCtrl(2, 0, 0, 0, 0)); cycle("R5 watch unpriv level3");
    isWatch = 0; setAll(mkCtrl(1, 1, 0, 0, 0)); curLevel = 1; cycle("R5 breakpoint unpriv ignored");
    unprivAccess = 0;
    // R6 gates
    setAll(mkCtrl(3, 1, 0, 0, 0));
    debugEnable = 0; cycle("R6 debug disabled");
    debugEnable = 1; eventsAllowed = 0; cycle("R6 events blocked");
    eventsAllowed = 1;
    // R7 / R8 / R9 links
    for (int j = 0; j < LE; j++) begin
      linkCtrl[j*64 +: 64] = mkLink(1, 3);
      linkVal[j*32 +: 32] = contextId;
    end
    setAll(mkCtrl(3, 1, 0, 4, 1)); cycle("R9 linked match entry4");
    setAll(mkCtrl(3, 1, 0, 5, 1)); cycle("R9 linked match entry5");
    setAll(mkCtrl(3, 1, 0, 3, 1)); cycle("R7 link below range");
    setAll(mkCtrl(3, 1, 0, 9, 1)); cycle("R7 link above range");
    setAll(mkCtrl(3, 1, 0, 4, 1));
    linkCtrl[4*64 +: 64] = mkLink(0, 3); cycle("R8 link disabled");
    linkCtrl[4*64 +: 64] = mkLink(1, 5); cycle("R8 link wrong type");
    linkCtrl[4*64 +: 64] = mkLink(1, 3);
    linkVal[4*32 +: 32] = 32'hdead_beef; cycle("R9 value mismatch");
    linkVal[4*32 +: 32] = contextId;
    curLevel = 2; cycle("R9 link at level2");
    isWatch = 1; unprivAccess = 1; cycle("R9 R5 unpriv does not lift link level");
    isWatch = 0; unprivAccess = 0; curLevel = 0; cycle("R9 link at level0");
    // random traffic
    for (int k = 0; k < 4000; k++) begin
      hitValid = ($urandom_range(0, 7) != 0);
      debugEnable = ($urandom_range(0, 7) != 0);
      eventsAllowed = ($urandom_range(0, 7) != 0);
      rawHit = NUM_CMP'($urandom);
      isWatch = 1'($urandom); unprivAccess = 1'($urandom); secure = 1'($urandom);
      curLevel = 2'($urandom);
      for (int i = 0; i < NUM_CMP; i++)
        ctrlWords[i*64 +: 64] = mkCtrl($urandom_range(0, 3), $urandom_range(0, 1),
          $urandom_range(0, 3), $urandom_range(2, 7), $urandom_range(0, 1));
      for (int j = 0; j < LE; j++) begin
        linkCtrl[j*64 +: 64] = mkLink(($urandom_range(0, 3) != 0) ? 1 : 0,
          ($urandom_range(0, 3) != 0) ? 3 : $urandom_range(0, 15));
        linkVal[j*32 +: 32] = ($urandom_range(0, 3) != 0) ? contextId : $urandom;
      end
      cycle("random R1 R2 R3 R4 R5 R6 R7 R8 R9 R10");
    end
    finishRun();
  end
endmodule